// File: doc/BRIEF.md
# Two-wire serial memory slave

This block is the slave side of a byte-wide serial memory of 2048 locations attached to a two-wire bus. It watches clock and data samples taken in the system clock domain. It detects start and stop conditions, decodes the select byte sent after each start, and answers with acknowledge bits and read data through an open-drain enable. Storage is a register array. Incoming write bytes are collected in a 16-entry page buffer and copied into the array when the master issues a stop.

An 11-bit location pointer sits between transactions. A write transaction loads it from three page-select bits in the select byte and a following 8-bit offset byte. A master that wants a random read sends that write preamble, then a repeated start and a read select byte. A master that sends only a read select byte gets a current-location read, which starts at the pointer as it stands. While reading, the pointer counts through the whole address space. While writing, only its low four bits count, so a long write wraps inside one 16-byte page.

Top module: `twi_mem_slave`

## Requirements
- R1: A stop (data rising while clock is high) returns the slave to idle with the data line released, and bytes clocked afterwards without a new start get no acknowledge. A start (data falling while clock is high) begins select-byte decoding at any point, including in the middle of a transfer.
- R2: The select byte is, MSB first, the prefix 1010, three page-select bits, then the direction bit (1 = read). A select byte with any other prefix gets no acknowledge, and the slave ignores the bus until the next start.
- R3: The slave acknowledges a matching select byte, the offset byte and every write data byte by pulling data low during the ninth clock. The enable rises only while clock is low, and it falls only while clock is low or right after a start or stop.
- R4: Write data bytes are stored at location {page-select, offset} and onward, and they become readable once the stop that ends the write has been seen.
- R5: During a write, each stored byte advances only the low four pointer bits. The upper seven bits stay fixed, so byte 17 of a write lands on the first location written.
- R6: A write preamble followed by a repeated start and a read select byte returns the data from the given location, MSB first, one data bit per clock low phase.
- R7: A read select byte with no preamble returns data starting at the current pointer and ignores the page-select bits it carries.
- R8: During a read, the whole 11-bit pointer advances after the eighth bit of each byte. It crosses page boundaries, and it wraps from 2047 to 0.
- R9: A read ends when the master answers a byte with no acknowledge. The slave then releases data and sends nothing more, even if clocks continue before the stop.
- R10: Reset clears the pointer to 0 and releases the data line. Array contents are kept.
- R11: Write bytes that have been received but not yet committed are discarded when a start arrives before a stop, and the array keeps its earlier contents.
- R12: After a write, the pointer holds the location after the last byte written, within the same page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The write and read paths are exercised with short writes inside one page, writes that start near the end of a page and run past its end, and reads that start near the top of the address space. These patterns separate the page-local write increment from the full-width read increment. Current-location reads use page-select bits that differ from the pointer's upper bits, which shows whether those bits are ignored. Writes cut off by a repeated start, select bytes with a wrong prefix, bytes clocked after a stop, and clocks after a read has ended show that only a proper start and stop move the slave between decoding and idle.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK
  } twi_state_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/twi_line_events.sv
// Turns sampled bus lines into single-cycle condition strobes.
module twi_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);

  logic scl_q, sda_q;
  logic scl_d, sda_d;

  always_comb begin
    scl_d = scl_i;
    sda_d = sda_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;

endmodule

// File: rtl/twi_addr_ptr.sv
// Location pointer: full-width count for reads, page-local count for writes.
module twi_addr_ptr #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              rd_inc,
  input  logic              wr_inc,
  output logic [ADDR_W-1:0] ptr
);

  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;
  logic [PAGE_W-1:0] low_next;

  always_comb begin
    low_next = ptr_q[PAGE_W-1:0] + 1'b1;
    ptr_en   = load | rd_inc | wr_inc;
    ptr_d    = ptr_q;
    if (load) begin
      ptr_d = load_val;
    end else if (rd_inc) begin
      ptr_d = ptr_q + 1'b1;
    end else if (wr_inc) begin
      ptr_d = {ptr_q[ADDR_W-1:PAGE_W], low_next};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

  logic [BASE_W-1:0] unused_base;
  assign unused_base = ptr_q[ADDR_W-1:PAGE_W];

endmodule

// File: rtl/twi_page_store.sv
// Page buffer plus storage array; buffered bytes are copied on commit.
module twi_page_store #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     we,
  input  logic [PAGE_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     commit,
  input  logic [ADDR_W-PAGE_W-1:0] base,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] mem_q  [DEPTH];
  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (clr || commit) begin
      vld_d = '0;
    end else if (we) begin
      vld_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      slot_q[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (vld_q[i]) begin
          mem_q[{base, PAGE_W'(i)}] <= slot_q[i];
        end
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int SEL_W  = ADDR_W - DATA_W;
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int CNT_W  = 4;
  localparam logic [CNT_W-1:0] BITS_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(DATA_W);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic rst_int_n;
  assign rst_int_n = rst_s2_q;

  logic start_ev, stop_ev, scl_rise, scl_fall;

  twi_line_events u_events (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  twi_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              oe_q, oe_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;

  logic              ptr_load, rd_inc, wr_inc, buf_we, dev_nak;
  logic [ADDR_W-1:0] ptr_val, ptr;
  logic [DATA_W-1:0] rd_data;
  logic              rx_active, byte_done, prefix_ok;

  twi_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (ptr_load),
    .load_val (ptr_val),
    .rd_inc   (rd_inc),
    .wr_inc   (wr_inc),
    .ptr      (ptr)
  );

  twi_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (start_ev),
    .we      (buf_we),
    .wr_idx  (ptr[PAGE_W-1:0]),
    .wr_data (shreg_q),
    .commit  (stop_ev),
    .base    (ptr[ADDR_W-1:PAGE_W]),
    .rd_addr (ptr),
    .rd_data (rd_data)
  );

  assign rx_active = (state_q == ST_DEV) || (state_q == ST_WADR) || (state_q == ST_WDAT);
  assign byte_done = scl_fall && (cnt_q == BITS_FULL);
  assign prefix_ok = (shreg_q[DATA_W-1:DATA_W-4] == DEV_PREFIX);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    oe_d     = oe_q;
    sel_d    = sel_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    ptr_load = 1'b0;
    ptr_val  = {sel_q, shreg_q};
    rd_inc   = 1'b0;
    wr_inc   = 1'b0;
    buf_we   = 1'b0;
    dev_nak  = 1'b0;

    if (start_ev) begin
      state_d = ST_DEV;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_ev) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      if (rx_active && scl_rise && (cnt_q < BITS_FULL)) begin
        shreg_d = {shreg_q[DATA_W-2:0], sda_i};
        cnt_d   = cnt_q + 1'b1;
      end
      unique case (state_q)
        ST_DEV: begin
          if (byte_done) begin
            cnt_d = '0;
            if (prefix_ok) begin
              oe_d    = 1'b1;
              sel_d   = shreg_q[SEL_W:1];
              rw_d    = shreg_q[0];
              state_d = ST_DEV_ACK;
            end else begin
              dev_nak = 1'b1;
              state_d = ST_IDLE;
            end
          end
        end
        ST_WADR: begin
          if (byte_done) begin
            cnt_d    = '0;
            ptr_load = 1'b1;
            oe_d     = 1'b1;
            state_d  = ST_WADR_ACK;
          end
        end
        ST_WDAT: begin
          if (byte_done) begin
            cnt_d   = '0;
            buf_we  = 1'b1;
            wr_inc  = 1'b1;
            oe_d    = 1'b1;
            state_d = ST_WDAT_ACK;
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              shreg_d = rd_data;
              oe_d    = ~rd_data[DATA_W-1];
              state_d = ST_RDAT;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WADR;
            end
          end
        end
        ST_WADR_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            cnt_d   = '0;
            oe_d    = 1'b0;
            state_d = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (cnt_q == BITS_LAST) begin
              rd_inc  = 1'b1;
              cnt_d   = '0;
              oe_d    = 1'b0;
              state_d = ST_RACK;
            end else begin
              cnt_d   = cnt_q + 1'b1;
              shreg_d = {shreg_q[DATA_W-2:0], 1'b0};
              oe_d    = ~shreg_q[DATA_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_i;
          end
          if (scl_fall) begin
            cnt_d = '0;
            if (mack_q) begin
              shreg_d = rd_data;
              oe_d    = ~rd_data[DATA_W-1];
              state_d = ST_RDAT;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      oe_q    <= 1'b0;
      sel_q   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      oe_q    <= oe_d;
      sel_q   <= sel_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe = oe_q;

  logic [BASE_W-1:0] unused_hi;
  assign unused_hi = ptr[ADDR_W-1:PAGE_W];

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              rd_inc,
  input logic              wr_inc,
  input logic              dev_nak,
  input logic [ADDR_W-1:0] ptr
);

  // R3: a pull-down begins only in the clock low phase
  p_pull_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R3: a release happens in the clock low phase or right after a bus condition
  p_release_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_i || $past(start_ev) || $past(stop_ev)));

  // R1: a stop leaves the line released
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R2: a foreign prefix is never acknowledged
  p_bad_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dev_nak |=> !sda_oe);

  // R5: a write step keeps the upper pointer bits and counts the low ones
  p_write_in_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inc |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])) &&
               (ptr[PAGE_W-1:0] == PAGE_W'($past(ptr[PAGE_W-1:0]) + 1'b1)));

  // R8: a read step advances the full pointer with wrap
  p_read_full_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_inc |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

endmodule

bind twi_mem_slave twi_mem_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .rd_inc   (rd_inc),
  .wr_inc   (wr_inc),
  .dev_nak  (dev_nak),
  .ptr      (ptr)
);

// File: tb/twi_mem_slave_tb.sv
module twi_mem_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int WATCHDOG   = 150000;

  logic clk, rst_n, scl_m, sda_m;
  logic sda_oe;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  twi_mem_slave u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0]  model [0:2047];
  logic [10:0] mptr;
  logic [7:0]  wbuf  [0:31];
  logic [7:0]  rbuf  [0:31];

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hold();
    scl_m = 1'b1; hold(); hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    ack = ~sda_line;
    hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold();
      scl_m = 1'b1; hold();
      b[i] = sda_line;
      hold();
      scl_m = 1'b0;
    end
    hold();
    send_bit(~mack);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [2:0] sel, input logic [7:0] wa, input int n, input string req);
    logic ack;
    logic [6:0] base;
    logic [3:0] off;
    bus_start();
    send_byte({4'hA, sel, 1'b0}, ack); check({req, " select ack"}, 32'(ack), 1);
    send_byte(wa, ack);                check({req, " offset ack"}, 32'(ack), 1);
    base = {sel, wa[7:4]};
    off  = wa[3:0];
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);         check({req, " data ack"}, 32'(ack), 1);
      model[{base, off}] = wbuf[i];
      off = off + 4'd1;
    end
    bus_stop();
    mptr = {base, off};
  endtask

  task automatic do_rand_read(input logic [2:0] sel, input logic [7:0] wa, input int n, input string req);
    logic ack;
    logic [10:0] a;
    bus_start();
    send_byte({4'hA, sel, 1'b0}, ack); check({req, " select ack"}, 32'(ack), 1);
    send_byte(wa, ack);                check({req, " offset ack"}, 32'(ack), 1);
    bus_start();
    send_byte({4'hA, sel, 1'b1}, ack); check({req, " read select ack"}, 32'(ack), 1);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
    bus_stop();
    a = {sel, wa};
    for (int i = 0; i < n; i++) begin
      check({req, " read data"}, 32'(rbuf[i]), 32'(model[a]));
      a = a + 11'd1;
    end
    mptr = a;
  endtask

  task automatic do_cur_read(input logic [2:0] sel, input int n, input string req);
    logic ack;
    bus_start();
    send_byte({4'hA, sel, 1'b1}, ack); check({req, " read select ack"}, 32'(ack), 1);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
    bus_stop();
    for (int i = 0; i < n; i++) begin
      check({req, " current data"}, 32'(rbuf[i]), 32'(model[mptr]));
      mptr = mptr + 11'd1;
    end
  endtask

  // R10: line released during and after reset
  task automatic t_reset_state();
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 oe in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 oe after reset", 32'(sda_oe), 0);
  endtask

  // R10: pointer back at 0 after reset, array kept
  task automatic t_ptr_after_reset();
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
    do_write(3'd0, 8'h00, 2, "R3 R4");
    rst_n = 1'b0; hold();
    rst_n = 1'b1; hold();
    mptr = 11'd0;
    do_cur_read(3'd6, 1, "R10");
  endtask

  // R4 R6: page write then random read of the same locations
  task automatic t_page_write();
    wbuf[0] = 8'h81; wbuf[1] = 8'h7E; wbuf[2] = 8'h00; wbuf[3] = 8'hFF;
    do_write(3'd5, 8'h30, 4, "R4");
    do_rand_read(3'd5, 8'h30, 4, "R6");
  endtask

  // R12 R7: pointer after a write; read ignores page bits
  task automatic t_current_after_write();
    wbuf[0] = 8'h10; wbuf[1] = 8'h21; wbuf[2] = 8'h32; wbuf[3] = 8'h43;
    do_write(3'd2, 8'h40, 4, "R4");
    wbuf[0] = 8'hE0; wbuf[1] = 8'hE1; wbuf[2] = 8'hE2;
    do_write(3'd2, 8'h40, 3, "R4");
    check("R12 pointer model", 32'(mptr), 32'h243);
    do_cur_read(3'd7, 1, "R7 R12");
  endtask

  // R5 R8: write wraps in page; read crosses into the next page
  task automatic t_page_wrap();
    wbuf[0] = 8'hC3;
    do_write(3'd1, 8'h20, 1, "R5");
    for (int i = 0; i < 18; i++) wbuf[i] = 8'(8'h40 + i);
    do_write(3'd1, 8'h1E, 18, "R5");
    check("R5 wrapped byte", 32'(model[11'h11E]), 32'h50);
    do_rand_read(3'd1, 8'h10, 17, "R5 R8");
  endtask

  // R8: read wraps from the top location to 0
  task automatic t_top_wrap();
    wbuf[0] = 8'h9C; wbuf[1] = 8'h3D;
    do_write(3'd7, 8'hFE, 2, "R4");
    do_rand_read(3'd7, 8'hFE, 3, "R8");
    check("R8 pointer wrapped", 32'(mptr), 32'h001);
  endtask

  // R2: wrong prefix gets no acknowledge
  task automatic t_bad_prefix();
    logic ack;
    bus_start();
    send_byte(8'hB0, ack); check("R2 foreign prefix", 32'(ack), 0);
    send_byte(8'h12, ack); check("R2 byte after foreign prefix", 32'(ack), 0);
    bus_stop();
  endtask

  // R11: start before stop drops buffered bytes
  task automatic t_restart_discard();
    logic ack;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    do_write(3'd3, 8'h00, 2, "R4");
    bus_start();
    send_byte(8'hA6, ack); check("R11 select ack", 32'(ack), 1);
    send_byte(8'h00, ack); check("R11 offset ack", 32'(ack), 1);
    send_byte(8'h99, ack); check("R11 data ack", 32'(ack), 1);
    send_byte(8'h88, ack); check("R11 data ack", 32'(ack), 1);
    do_rand_read(3'd3, 8'h00, 2, "R11 R1");
  endtask

  // R1: no decoding after stop without a start
  task automatic t_stop_idle();
    logic ack;
    send_byte(8'hA0, ack); check("R1 byte after stop", 32'(ack), 0);
    bus_stop();
  endtask

  // R9: nothing is driven after a not-acknowledge
  task automatic t_nack_end();
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hAA, ack); check("R9 select ack", 32'(ack), 1);
    send_byte(8'h30, ack); check("R9 offset ack", 32'(ack), 1);
    bus_start();
    send_byte(8'hAB, ack); check("R9 read select ack", 32'(ack), 1);
    recv_byte(1'b0, b);    check("R9 last byte", 32'(b), 32'(model[11'h530]));
    recv_byte(1'b0, b);    check("R9 released after nack", 32'(b), 32'hFF);
    bus_stop();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mptr = '0;
    t_reset_state();
    t_ptr_after_reset();
    t_page_write();
    t_current_after_write();
    t_page_wrap();
    t_top_wrap();
    t_bad_prefix();
    t_restart_discard();
    t_stop_idle();
    t_nack_end();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule